// File: doc/BRIEF.md
# Global Configuration and Power Control Register

This block is the chip-wide configuration register that sits on the host bus of a multi-channel serial controller. The host reaches it at either of two addresses. It holds four things: the power-down bit, the two-bit interrupt vector control field, a bus-cycle mode flag, and a reserved guard bit. From these it drives plain control outputs that the rest of the chip uses. The power-down output stops the channel engines and the clock tree. The vector control field goes to the vector formation logic. The addressing-enable output gates the other register decoders.

The bus-cycle mode can change in one direction only. Its reset value is asynchronous cycles of any length. A single host write that sets the mode bit arms the change to synchronous four-clock cycles. The change takes effect on the first clock edge at which chip-enable is seen high after that write. A guard window of `GUARD_CYC` clocks then passes before the block reports that synchronous cycles may start. Only a hardware reset or the software reset strobe returns the block to asynchronous mode. In synchronous mode, back-to-back accesses with chip-enable held low are all accepted.

The interface is a plain register port: chip-enable, write and read qualifiers, an address and data. There is no streaming path, so valid/ready handshakes do not apply.

Top module: `gcfg_reg`

## Requirements
- R1: After hardware reset (`rst_n` low), `pwr_down`=0, `ivec_ctl`=0, `sync_mode`=0, `sync_ready`=0 and `addr_enable`=1. A read returns 8'h00.
- R2: A write (cs_n=0, wr_en=1) to `ALIAS_LO` or `ALIAS_HI` updates bit 0, bits 2:1 and bit 7 from `wdata`. A read (cs_n=0, rd_en=1) at either address returns them in the same positions. Bits 5:3 always read 0.
- R3: A write to any other address, or a write with cs_n=1, leaves the contents unchanged. `rdata` is 8'h00 whenever no read hits an alias.
- R4: `pwr_down` equals the stored bit 0 (1 = powered down).
- R5: `ivec_ctl` equals the stored bits 2:1.
- R6: `addr_enable` is the inverse of the stored bit 7.
- R7: While in asynchronous mode, a write with `wdata[6]`=1 arms the switch. `sync_mode` rises on the first clock edge after that write at which cs_n=1. Until then, read bit 6 stays 0. Afterwards, read bit 6 equals `sync_mode`.
- R8: `sync_ready` is 0 on the commit edge and rises exactly `GUARD_CYC` (default 2) clock edges after the commit edge.
- R9: Once `sync_mode` is 1, writing bit 6 as 0 does not clear it. Only a reset clears it.
- R10: A one-cycle `sw_rst` pulse has the same effect on all state and outputs as a hardware reset.
- R11: In synchronous mode, consecutive writes with cs_n held low across them are each accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset strobe |
| cs_n | input | 1 | Chip-enable, active low |
| wr_en | input | 1 | Write qualifier |
| rd_en | input | 1 | Read qualifier |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read hits |
| pwr_down | output | 1 | Power-down enable for channels and clock |
| ivec_ctl | output | 2 | Interrupt vector control field |
| sync_mode | output | 1 | Synchronous bus-cycle mode in effect |
| sync_ready | output | 1 | Guard window after mode switch has elapsed |
| addr_enable | output | 1 | Other register addressing allowed |

## Verification
The assertions assume that `sw_rst` is a synchronous strobe and that the host brings cs_n high at some point after the arming write. A mode commit can only be observed on such an edge. The bench holds cs_n low for an extra cycle after the arming write to show that the commit waits. It releases chip-enable before looking for the commit. It drives all inputs at the falling edge, so no input changes near the sampling edge.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_PD    = 0;
  localparam int IVC_LSB   = 1;
  localparam int IVC_W     = 2;
  localparam int BIT_SYNC  = 6;
  localparam int BIT_LOCK  = 7;

  typedef struct packed {
    logic             lock;
    logic [IVC_W-1:0] ivc;
    logic             pd;
  } cfg_t;
endpackage

// File: rtl/gcfg_decode.sv
module gcfg_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_ALIAS = 2,
  parameter logic [NUM_ALIAS*ADDR_W-1:0] ALIASES = '0
) (
  input  logic              cs_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic [NUM_ALIAS-1:0] match;

  for (genvar g = 0; g < NUM_ALIAS; g++) begin : g_alias
    assign match[g] = (addr == ALIASES[g*ADDR_W +: ADDR_W]);
  end

  assign wr_hit = !cs_n && wr_en && (|match);
  assign rd_hit = !cs_n && rd_en && (|match);
endmodule

// File: rtl/gcfg_store.sv
module gcfg_store
  import gcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  output cfg_t             cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (sw_rst) begin
      cfg <= '0;
    end else if (wr_hit) begin
      cfg.lock <= wdata[BIT_LOCK];
      cfg.ivc  <= wdata[IVC_LSB +: IVC_W];
      cfg.pd   <= wdata[BIT_PD];
    end
  end

  p_hold_without_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !sw_rst) |=> $stable(cfg));

  p_swrst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (cfg == '0));
endmodule

// File: rtl/gcfg_mode_seq.sv
module gcfg_mode_seq #(
  parameter int GUARD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic wr_hit,
  input  logic req_sync,
  input  logic cs_n,
  output logic sync_mode,
  output logic sync_ready
);
  localparam int CNT_W = $clog2(GUARD_CYC + 1);
  localparam logic [CNT_W-1:0] GUARD_LOAD = CNT_W'(GUARD_CYC);

  logic             armed;
  logic [CNT_W-1:0] guard_cnt;
  logic             commit;

  assign commit = armed && cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      sync_mode <= 1'b0;
      guard_cnt <= '0;
    end else if (sw_rst) begin
      armed     <= 1'b0;
      sync_mode <= 1'b0;
      guard_cnt <= '0;
    end else begin
      if (commit) begin
        armed     <= 1'b0;
        sync_mode <= 1'b1;
        guard_cnt <= GUARD_LOAD;
      end else begin
        if (!sync_mode && wr_hit && req_sync) armed <= 1'b1;
        if (guard_cnt != '0) guard_cnt <= guard_cnt - 1'b1;
      end
    end
  end

  assign sync_ready = sync_mode && (guard_cnt == '0);

  p_oneway_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !sw_rst) |=> sync_mode);

  p_commit_on_negate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_mode) |-> $past(cs_n));

  p_guard_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_mode) |-> !sync_ready);

  p_ready_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ready && !sw_rst) |=> sync_ready);
endmodule

// File: rtl/gcfg_reg.sv
module gcfg_reg
  import gcfg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ALIAS_LO = 8'h1E,
  parameter logic [ADDR_W-1:0] ALIAS_HI = 8'h5E,
  parameter int GUARD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              cs_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              pwr_down,
  output logic [1:0]        ivec_ctl,
  output logic              sync_mode,
  output logic              sync_ready,
  output logic              addr_enable
);
  logic wr_hit, rd_hit;
  cfg_t cfg;

  gcfg_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_ALIAS(2),
    .ALIASES  ({ALIAS_HI, ALIAS_LO})
  ) u_decode (
    .cs_n  (cs_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wr_hit(wr_hit),
    .rd_hit(rd_hit)
  );

  gcfg_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .sw_rst(sw_rst),
    .wr_hit(wr_hit),
    .wdata (wdata),
    .cfg   (cfg)
  );

  gcfg_mode_seq #(.GUARD_CYC(GUARD_CYC)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rst    (sw_rst),
    .wr_hit    (wr_hit),
    .req_sync  (wdata[BIT_SYNC]),
    .cs_n      (cs_n),
    .sync_mode (sync_mode),
    .sync_ready(sync_ready)
  );

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      rdata[BIT_LOCK]              = cfg.lock;
      rdata[BIT_SYNC]              = sync_mode;
      rdata[IVC_LSB +: IVC_W]      = cfg.ivc;
      rdata[BIT_PD]                = cfg.pd;
    end
  end

  assign pwr_down    = cfg.pd;
  assign ivec_ctl    = cfg.ivc;
  assign addr_enable = !cfg.lock;

  p_pd_follows_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !sw_rst) |=> (pwr_down == $past(wdata[BIT_PD])));

  p_hwrst_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sync_mode && !pwr_down && addr_enable));
endmodule

// File: tb/test_gcfg_reg.sv
module test_gcfg_reg;
  localparam logic [7:0] A_LO = 8'h1E;
  localparam logic [7:0] A_HI = 8'h5E;

  logic clk = 1'b0;
  logic rst_n, sw_rst, cs_n, wr_en, rd_en;
  logic [7:0] addr, wdata, rdata;
  logic pwr_down, sync_mode, sync_ready, addr_enable;
  logic [1:0] ivec_ctl;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gcfg_reg i_gcfg_reg (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cs_n(cs_n),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwr_down(pwr_down), .ivec_ctl(ivec_ctl),
    .sync_mode(sync_mode), .sync_ready(sync_ready), .addr_enable(addr_enable)
  );

  // {write address, write data, read address, expected readback}
  localparam int NV = 7;
  localparam logic [NV-1:0][31:0] VEC = {
    {A_LO, 8'h00, A_HI, 8'h00},
    {A_HI, 8'h02, A_LO, 8'h02},
    {A_LO, 8'h85, A_HI, 8'h85},
    {A_HI, 8'h3D, A_LO, 8'h05},
    {A_LO, 8'h06, A_HI, 8'h06},
    {A_HI, 8'h81, A_HI, 8'h81},
    {A_LO, 8'h01, A_LO, 8'h01}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_en = 1'b1; addr = a;
    #1 d = rdata;
    cs_n = 1'b1; rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; sw_rst = 1'b0; cs_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 pwr_down", {7'b0, pwr_down}, 8'h00);
    chk("R1 ivec_ctl", {6'b0, ivec_ctl}, 8'h00);
    chk("R1 sync", {6'b0, sync_mode, sync_ready}, 8'h00);
    chk("R1 addr_enable", {7'b0, addr_enable}, 8'h01);
    do_read(A_LO, rd);
    chk("R1 readback", rd, 8'h00);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][31:24], VEC[i][23:16]);
      do_read(VEC[i][15:8], rd);
      chk("R2 alias readback", rd, VEC[i][7:0]);
      chk("R4 pwr_down", {7'b0, pwr_down}, {7'b0, VEC[i][0]});
      chk("R5 ivec_ctl", {6'b0, ivec_ctl}, {6'b0, VEC[i][2:1]});
      chk("R6 addr_enable", {7'b0, addr_enable}, {7'b0, ~VEC[i][7]});
    end

    // R3: miss address and inactive chip-enable
    do_write(8'h1F, 8'h87);
    do_read(A_LO, rd);
    chk("R3 wrong address write", rd, 8'h00);
    @(negedge clk);
    cs_n = 1'b1; wr_en = 1'b1; addr = A_LO; wdata = 8'h07;
    @(negedge clk);
    wr_en = 1'b0;
    do_read(A_HI, rd);
    chk("R3 write with cs_n high", rd, 8'h00);
    chk("R3 pwr_down unchanged", {7'b0, pwr_down}, 8'h00);
    do_write(A_LO, 8'h03);
    do_read(8'h5F, rd);
    chk("R3 read miss", rd, 8'h00);
    do_write(A_LO, 8'h00);

    // R7/R8: arm sync while holding cs_n low, then release
    @(negedge clk);
    cs_n = 1'b0; wr_en = 1'b1; addr = A_LO; wdata = 8'h40;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1;
    #1;
    chk("R7 bit6 before commit", rdata, 8'h00);
    chk("R7 sync before commit", {7'b0, sync_mode}, 8'h00);
    @(negedge clk);
    #1;
    chk("R7 still async with cs_n low", {7'b0, sync_mode}, 8'h00);
    rd_en = 1'b0; cs_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R7 commit on release", {7'b0, sync_mode}, 8'h01);
    chk("R8 ready low at commit", {7'b0, sync_ready}, 8'h00);
    @(negedge clk);
    #1;
    chk("R8 ready low one edge later", {7'b0, sync_ready}, 8'h00);
    @(negedge clk);
    #1;
    chk("R8 ready after guard", {7'b0, sync_ready}, 8'h01);
    do_read(A_HI, rd);
    chk("R7 readback bit6", rd, 8'h40);

    // R9: clearing bit 6 has no effect
    do_write(A_HI, 8'h00);
    do_read(A_LO, rd);
    chk("R9 sync sticky", rd, 8'h40);
    chk("R9 sync_mode", {7'b0, sync_mode}, 8'h01);

    // R11: back-to-back writes with cs_n held low
    @(negedge clk);
    cs_n = 1'b0; wr_en = 1'b1; addr = A_LO; wdata = 8'h01;
    @(negedge clk);
    addr = A_HI; wdata = 8'h04;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = A_LO;
    #1;
    chk("R11 second write kept", rdata, 8'h44);
    chk("R11 pwr_down from second write", {7'b0, pwr_down}, 8'h00);
    rd_en = 1'b0; cs_n = 1'b1;

    // R10: software reset
    do_write(A_LO, 8'h87);
    @(negedge clk);
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    #1;
    chk("R10 sync cleared", {6'b0, sync_mode, sync_ready}, 8'h00);
    chk("R10 outputs cleared", {4'b0, addr_enable, ivec_ctl, pwr_down}, 8'h08);
    do_read(A_HI, rd);
    chk("R10 readback", rd, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule